// File: doc/BRIEF.md
# Direction-Selected SPI Slave FIFO

This block is an SPI slave (mode 0, MSB first) with one byte FIFO for each direction, clocked entirely from the system clock. SCLK, MOSI and the active-low chip select are brought in through multi-flop synchronizers, and the SCLK edges are found in the system domain. The first byte of every chip-select frame is a command byte whose least significant bit picks a one-way transfer. With bit 0 clear, the frame is a write: the bytes that follow go into the receive FIFO, and MISO stays undriven. With bit 0 set, the frame is a read: bytes from the transmit FIFO are shifted out on MISO, and everything the master sends is thrown away.

The host side is a plain register interface. It has a control word holding enable, SPI-select, transmit-enable and receive-enable bits, a push port for the transmit FIFO, and a show-ahead pop port for the receive FIFO. A status word reports both fill levels, two sticky error flags and a frame-busy bit. A strobe clears the error flags. Clearing the transmit enable in a control write empties the transmit FIFO. The break bit is kept in the control word but does nothing in this mode.

Top module: `spi_dirsel_slave`

## Requirements
- R1: A frame whose command byte has bit 0 = 0 is a write frame. Every later complete byte is pushed into the RX FIFO in arrival order. The command byte itself is never stored. For example, sending 0x00,0x0d,0x0e,0x0a,0x0d leaves exactly 0x0d,0x0e,0x0a,0x0d.
- R2: During a write frame, miso_oe is 0 and spi_miso is 0.
- R3: A frame whose command byte has bit 0 = 1 is a read frame. The byte returned while the command byte is clocked in is 0x00, and TX FIFO bytes follow from the second byte on. MOSI data in a read frame never reaches the RX FIFO.
- R4: Mode 0 timing applies. MOSI is sampled on the rising SCLK edge, MISO changes only after a falling SCLK edge, and bytes travel MSB first.
- R5: A write-frame byte that arrives while the RX FIFO (FIFO_DEPTH entries, 16 by default) is full is dropped, and the sticky overrun flag is set.
- R6: If a read-frame byte is started while the TX FIFO is empty and transmit enable is 1, that byte is sent as 0x00 and the sticky underrun flag is set.
- R7: A one-cycle stat_clr pulse clears both the overrun and the underrun flag.
- R8: A control write that changes transmit enable (bit 8) from 1 to 0 empties the TX FIFO. After transmit enable is set again, the TX level is 0.
- R9: The break bit (bit 7) of the control word has no effect on either FIFO.
- R10: If chip select deasserts in the middle of a byte, the partial byte is discarded, and the next frame starts again with a command byte.
- R11: The device responds only when control bit 0 (enable) and bit 1 (SPI select) are both 1, so 0x303 enables both directions and 0 disables. With receive enable (bit 9) at 0, write-frame bytes are dropped without setting overrun.
- R12: The status word is laid out as follows: [4:0] RX level, [9:5] TX level, [10] overrun, [11] underrun, [12] frame in progress (chip select asserted while the device is enabled). These are the positions for FIFO_DEPTH=16.
- R13: After reset, the control word is 0, both FIFOs are empty, both flags are 0 and miso_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_mosi | input | 1 | Master-out data |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Slave-out data |
| miso_oe | output | 1 | MISO output enable, high only in a read frame |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 10 | Control word write data |
| ctrl_q | output | 10 | Current control word |
| tx_push | input | 1 | Push tx_wdata into the TX FIFO |
| tx_wdata | input | 8 | TX FIFO write data |
| rx_pop | input | 1 | Pop the RX FIFO head |
| rx_rdata | output | 8 | RX FIFO head (show-ahead) |
| stat_clr | input | 1 | Clear the overrun and underrun flags |
| status_o | output | 13 | Levels, flags and busy bit |

## Verification
Each SPI edge reaches the frame engine three system clocks after the pin moves (two synchronizer flops, then the edge register), and an RX push or TX pop becomes visible in status one clock after that. The bench therefore holds each SCLK phase for eight clocks. It samples MISO at the end of the low phase, well after the falling-edge update, and reads status only after chip select has been high for at least twelve clocks. Host pushes and pops are driven and sampled on falling clock edges, so their effect shows in status at the next falling edge.

// File: rtl/spi_dirsel_pkg.sv
package spi_dirsel_pkg;

   localparam int CTRL_W = 10;
   localparam int CB_EN  = 0;
   localparam int CB_SPI = 1;
   localparam int CB_BRK = 7;
   localparam int CB_TE  = 8;
   localparam int CB_RE  = 9;

   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2
   } phase_t;

endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sd_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sd_fifo.sv
module sd_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sd_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [LW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign level   = wp - rp;
   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;
   assign rdata   = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp[AW-1:0]] <= wdata;
   end

   // R5: a push into a full FIFO leaves the fill level unchanged
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> (level == LW'(DEPTH)));

   // R6: a pop from an empty FIFO never wraps the level
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/sd_frame.sv
module sd_frame
   import spi_dirsel_pkg::*;
#(
   parameter int DW = 8,
   localparam int BW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          te,
   input  logic          re,
   input  logic          sclk_s,
   input  logic          mosi_s,
   input  logic          csn_s,
   input  logic          tx_empty,
   input  logic [DW-1:0] tx_rdata,
   output logic          tx_pop,
   input  logic          rx_full,
   output logic          rx_push,
   output logic [DW-1:0] rx_wdata,
   output logic          ovr_ev,
   output logic          und_ev,
   output logic          miso,
   output logic          miso_oe,
   output logic          busy
);
   if (DW < 2 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("sd_frame: DW must be a power of two");
   end

   phase_t        phase_q;
   logic [BW-1:0] bit_q;
   logic [DW-1:0] rx_sh, tx_sh;
   logic          have_q, sclk_q;
   logic          in_frame, rise, fall, done, first_rise;
   logic [DW-1:0] byte_w;

   assign in_frame   = active && !csn_s;
   assign rise       = in_frame && sclk_s && !sclk_q;
   assign fall       = in_frame && !sclk_s && sclk_q;
   assign byte_w     = {rx_sh[DW-2:0], mosi_s};
   assign done       = rise && (bit_q == BW'(DW-1));
   assign first_rise = rise && (phase_q == PH_READ) && (bit_q == '0);

   assign rx_wdata = byte_w;
   assign rx_push  = done && (phase_q == PH_WRITE) && re && !rx_full;
   assign ovr_ev   = done && (phase_q == PH_WRITE) && re && rx_full;
   assign tx_pop   = first_rise && te && have_q;
   assign und_ev   = first_rise && te && !have_q;

   assign miso_oe = in_frame && (phase_q == PH_READ);
   assign miso    = miso_oe && tx_sh[DW-1];
   assign busy    = in_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         phase_q <= PH_CMD;
         bit_q   <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         have_q  <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         if (!in_frame) begin
            phase_q <= PH_CMD;
            bit_q   <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            have_q  <= 1'b0;
         end else if (rise) begin
            rx_sh <= byte_w;
            bit_q <= bit_q + 1'b1;
            if (done && phase_q == PH_CMD)
               phase_q <= byte_w[0] ? PH_READ : PH_WRITE;
         end else if (fall && phase_q == PH_READ) begin
            if (bit_q == '0) begin
               tx_sh  <= (te && !tx_empty) ? tx_rdata : '0;
               have_q <= te && !tx_empty;
            end else begin
               tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
         end
      end
   end

   // R1: only data bytes of a write frame reach the RX FIFO
   p_cmd_not_stored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (phase_q == PH_WRITE));

   // R2: MISO stays quiet for the whole write frame
   p_quiet_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WRITE) |-> (!miso && !miso_oe));

   // R3: the TX FIFO is drained only by read frames
   p_pop_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> (phase_q == PH_READ));

   // R4: MISO moves only after a falling SCLK edge inside a read frame
   p_miso_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && phase_q == PH_READ && !fall) |=> (!in_frame || $stable(miso)));
endmodule

// File: rtl/spi_dirsel_slave.sv
module spi_dirsel_slave
   import spi_dirsel_pkg::*;
#(
   parameter int DW          = 8,
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LW         = $clog2(FIFO_DEPTH) + 1,
   localparam int SW         = 2 * LW + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   input  logic              spi_cs_n,
   output logic              spi_miso,
   output logic              miso_oe,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   input  logic              tx_push,
   input  logic [DW-1:0]     tx_wdata,
   input  logic              rx_pop,
   output logic [DW-1:0]     rx_rdata,
   input  logic              stat_clr,
   output logic [SW-1:0]     status_o
);
   logic [CTRL_W-1:0] ctrl_r;
   logic              active, te, re, tx_flush;
   logic              sclk_s, mosi_s, csn_s;
   logic              tx_pop, tx_empty, tx_full;
   logic              rx_push, rx_full, rx_empty;
   logic [DW-1:0]     rx_wdata, tx_rdata;
   logic [LW-1:0]     rx_level, tx_level;
   logic              ovr_ev, und_ev, ovr_q, und_q, busy;
   logic              tx_full_unused, rx_empty_unused;

   assign active   = ctrl_r[CB_EN] && ctrl_r[CB_SPI];
   assign te       = ctrl_r[CB_TE];
   assign re       = ctrl_r[CB_RE];
   assign tx_flush = ctrl_we && ctrl_r[CB_TE] && !ctrl_wdata[CB_TE];
   assign ctrl_q   = ctrl_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_r <= '0;
         ovr_q  <= 1'b0;
         und_q  <= 1'b0;
      end else begin
         if (ctrl_we) ctrl_r <= ctrl_wdata;
         ovr_q <= ovr_ev || (ovr_q && !stat_clr);
         und_q <= und_ev || (und_q && !stat_clr);
      end
   end

   sd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_mosi, spi_sclk}),
      .q     ({csn_s, mosi_s, sclk_s})
   );

   sd_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (1'b0),
      .push  (rx_push),
      .wdata (rx_wdata),
      .pop   (rx_pop),
      .rdata (rx_rdata),
      .full  (rx_full),
      .empty (rx_empty),
      .level (rx_level)
   );

   sd_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tx_flush),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_pop),
      .rdata (tx_rdata),
      .full  (tx_full),
      .empty (tx_empty),
      .level (tx_level)
   );

   assign tx_full_unused  = tx_full;
   assign rx_empty_unused = rx_empty;

   sd_frame #(.DW(DW)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .te       (te),
      .re       (re),
      .sclk_s   (sclk_s),
      .mosi_s   (mosi_s),
      .csn_s    (csn_s),
      .tx_empty (tx_empty),
      .tx_rdata (tx_rdata),
      .tx_pop   (tx_pop),
      .rx_full  (rx_full),
      .rx_push  (rx_push),
      .rx_wdata (rx_wdata),
      .ovr_ev   (ovr_ev),
      .und_ev   (und_ev),
      .miso     (spi_miso),
      .miso_oe  (miso_oe),
      .busy     (busy)
   );

   assign status_o = {busy, und_q, ovr_q, tx_level, rx_level};

   // R8: clearing transmit enable leaves the TX FIFO empty
   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> (tx_level == '0));

   // R7: the clear strobe drops both flags when no new event arrives
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !ovr_ev && !und_ev) |=> (!ovr_q && !und_q));

   // R11: a disabled device never fills the RX FIFO
   p_idle_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !rx_push);
endmodule

// File: tb/spi_dirsel_slave_tb.sv
module spi_dirsel_slave_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
   logic        spi_miso, miso_oe;
   logic        ctrl_we = 1'b0;
   logic [9:0]  ctrl_wdata = '0;
   logic [9:0]  ctrl_q;
   logic        tx_push = 1'b0;
   logic [7:0]  tx_wdata = '0;
   logic        rx_pop = 1'b0;
   logic [7:0]  rx_rdata;
   logic        stat_clr = 1'b0;
   logic [12:0] status_o;

   int checks = 0, fails = 0;
   bit done = 0;
   bit mon_en = 0;
   bit oe_seen = 0;
   logic [7:0] exp_q[$];
   logic [7:0] got_byte;
   string      mon_req;
   event       byte_ev;

   always #4 clk = ~clk;

   spi_dirsel_slave u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .miso_oe(miso_oe),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop),
      .rx_rdata(rx_rdata), .stat_clr(stat_clr), .status_o(status_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int rx_lvl(); return int'(status_o[4:0]); endfunction
   function automatic int tx_lvl(); return int'(status_o[9:5]); endfunction

   // monitor: compares each byte seen on MISO against the scoreboard queue
   initial begin
      forever begin
         @(byte_ev);
         if (mon_en) begin
            if (exp_q.size() == 0) chk(0, mon_req, int'(got_byte), -1);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(got_byte === e, mon_req, int'(got_byte), int'(e));
            end
         end
      end
   end

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [9:0] v);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 1'b0;
   endtask

   task automatic push_tx(input logic [7:0] v);
      @(negedge clk); tx_push = 1'b1; tx_wdata = v;
      @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic pop_rx(input logic [7:0] exp, input string req);
      @(negedge clk);
      chk(rx_rdata === exp, req, int'(rx_rdata), int'(exp));
      rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic spi_bits(input logic [7:0] mo, input int nbits);
      logic [7:0] mi = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         spi_mosi = mo[i];
         wclk(8);
         mi[i] = spi_miso;
         if (miso_oe) oe_seen = 1;
         spi_sclk = 1'b1;
         wclk(8);
         spi_sclk = 1'b0;
      end
      got_byte = mi;
      if (nbits == 8) -> byte_ev;
   endtask

   task automatic cs_low();
      spi_cs_n = 1'b0; wclk(8);
   endtask

   task automatic cs_high();
      wclk(4); spi_cs_n = 1'b1; wclk(12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      wclk(3); rst_n = 1'b1; wclk(3);
      // R13: reset state
      chk(status_o == 13'h0 && ctrl_q == 10'h0 && !miso_oe, "R13 reset", int'(status_o), 0);

      // R1, R2, R12: write frame
      wr_ctrl(10'h303);
      oe_seen = 0;
      cs_low();
      spi_bits(8'h00, 8);
      chk(status_o[12] === 1'b1, "R12 busy bit in frame", int'(status_o[12]), 1);
      spi_bits(8'h0d, 8); spi_bits(8'h0e, 8); spi_bits(8'h0a, 8); spi_bits(8'h0d, 8);
      cs_high();
      chk(!oe_seen, "R2 miso quiet in write frame", int'(oe_seen), 0);
      chk(rx_lvl() == 4, "R1 rx level after write", rx_lvl(), 4);
      pop_rx(8'h0d, "R1 byte0"); pop_rx(8'h0e, "R1 byte1");
      pop_rx(8'h0a, "R1 byte2"); pop_rx(8'h0d, "R1 byte3");

      // R3, R4: read frame through the scoreboard
      push_tx(8'h0b); push_tx(8'h0e); push_tx(8'h0e); push_tx(8'h0f);
      chk(tx_lvl() == 4, "R12 tx level field", tx_lvl(), 4);
      exp_q.push_back(8'h00); exp_q.push_back(8'h0b); exp_q.push_back(8'h0e);
      exp_q.push_back(8'h0e); exp_q.push_back(8'h0f);
      mon_req = "R3 R4 read frame byte"; mon_en = 1;
      cs_low();
      spi_bits(8'h01, 8); spi_bits(8'hff, 8); spi_bits(8'h00, 8);
      spi_bits(8'h5a, 8); spi_bits(8'h00, 8);
      cs_high();
      mon_en = 0;
      chk(exp_q.size() == 0, "R3 all read bytes seen", exp_q.size(), 0);
      chk(rx_lvl() == 0 && tx_lvl() == 0, "R3 mosi ignored, tx drained",
          int'(status_o[9:0]), 0);
      chk(status_o[11] == 1'b0, "R6 no underrun on exact drain", int'(status_o[11]), 0);

      // R6, R7: underrun and clear
      exp_q.push_back(8'h00); exp_q.push_back(8'h00);
      mon_req = "R6 empty tx sends zero"; mon_en = 1;
      cs_low(); spi_bits(8'h01, 8); spi_bits(8'h00, 8); cs_high();
      mon_en = 0;
      chk(status_o[11] == 1'b1, "R6 underrun set", int'(status_o[11]), 1);
      @(negedge clk); stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
      chk(status_o[11:10] == 2'b00, "R7 flags cleared", int'(status_o[11:10]), 0);

      // R5: overrun
      cs_low();
      spi_bits(8'h00, 8);
      for (int i = 1; i <= 17; i++) spi_bits(8'(i), 8);
      cs_high();
      chk(rx_lvl() == 16, "R5 rx full level", rx_lvl(), 16);
      chk(status_o[10] == 1'b1, "R5 overrun set", int'(status_o[10]), 1);
      for (int i = 1; i <= 16; i++) pop_rx(8'(i), "R5 kept byte");
      chk(status_o[10] == 1'b1, "R5 overrun sticky", int'(status_o[10]), 1);
      @(negedge clk); stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
      chk(status_o[10] == 1'b0, "R7 overrun cleared", int'(status_o[10]), 0);

      // R8: transmit flush
      push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
      wr_ctrl(10'h203);
      wr_ctrl(10'h303);
      chk(tx_lvl() == 0, "R8 tx flushed", tx_lvl(), 0);

      // R9: break bit has no effect
      push_tx(8'h44); push_tx(8'h55);
      cs_low(); spi_bits(8'h00, 8); spi_bits(8'h66, 8); spi_bits(8'h77, 8); cs_high();
      wr_ctrl(10'h383);
      wclk(2);
      chk(rx_lvl() == 2 && tx_lvl() == 2, "R9 break no effect", int'(status_o[9:0]), 'h42);
      pop_rx(8'h66, "R9 rx data kept");
      pop_rx(8'h77, "R9 rx data kept");
      wr_ctrl(10'h203); wr_ctrl(10'h303);

      // R10: aborted partial byte
      cs_low(); spi_bits(8'hf0, 4); cs_high();
      cs_low(); spi_bits(8'h00, 8); spi_bits(8'h55, 8); cs_high();
      chk(rx_lvl() == 1, "R10 partial byte dropped", rx_lvl(), 1);
      pop_rx(8'h55, "R10 next frame data");

      // R11: disabled device and receive disable
      wr_ctrl(10'h000);
      cs_low(); spi_bits(8'h00, 8);
      chk(status_o[12] == 1'b0, "R11 not busy when disabled", int'(status_o[12]), 0);
      spi_bits(8'h99, 8); cs_high();
      chk(rx_lvl() == 0, "R11 disabled ignores frame", rx_lvl(), 0);
      wr_ctrl(10'h103);
      cs_low(); spi_bits(8'h00, 8); spi_bits(8'h99, 8); cs_high();
      chk(rx_lvl() == 0 && status_o[10] == 1'b0, "R11 rx disabled drops quietly",
          int'(status_o[10:0]), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule